// File: doc/BRIEF.md
# Die-to-Die Link Bring-Up Sequencer

This block is the host-side controller that brings a chiplet link from power-on to an operational state. After the system reset is released it holds the peer die in reset until the reference clock is reported stable. It then keeps the peer's active-low reset low for a minimum number of cycles and releases it. Next it waits for the peer to report that link training is complete. It then runs a credit exchange: it issues a fixed number of initial transmit credits to the peer and counts the initial receive credits that the peer returns.

Link-up is raised only when both directions of the exchange are complete. A watchdog timer bounds the exchange. When it expires, or when the peer drops its training-done indication during the exchange or while the link is up, the controller records a sticky error and sends the peer through a full reset and retraining cycle. There is no partial retry. All durations are cycle counts derived from parameters, so the watchdog limit in microseconds becomes a whole number of cycles of the controller clock.

Top module: `d2d_linkup_ctrl`

## Requirements
- R1: While `rst_n` is low the block shows phase 0 (idle), with `peer_rst_n_o`, `link_up_o`, `err_o` and `tx_crd_vld_o` all low. On the first clock edge after reset it moves to phase 1. Phase codes are: 0 idle, 1 wait for clock, 2 peer reset hold, 3 training, 4 credit exchange, 5 active, 7 error.
- R2: In phase 1 the peer reset output stays low for as long as `clk_stable_i` is low. The edge after `clk_stable_i` is seen high moves the block to phase 2.
- R3: Phase 2 lasts exactly `HOLD_CYC` cycles with the peer reset low, and is followed by phase 3 with the peer reset high. If `clk_stable_i` drops during phase 2, the block returns to phase 1.
- R4: In phase 3 no transmit credit is issued until `train_done_i` is high. The edge after that moves the block to phase 4.
- R5: In phase 4 `tx_crd_vld_o` is high for exactly `CREDITS` (32 by default) consecutive cycles, starting with the first cycle of phase 4. Each high cycle is one credit.
- R6: A receive credit is one cycle with `rx_crd_vld_i` high. Receive credits are counted only in phase 4, and strobes at any other time have no effect. The link does not come up until `CREDITS` receive credits have arrived. Strobes beyond that count are ignored.
- R7: `link_up_o` is high exactly when the phase is 5. Phase 5 starts on the edge that follows the first cycle in which both all transmit credits have been sent and all receive credits have been counted.
- R8: If the exchange is not complete within `WDOG_CYC` = `CLK_MHZ`*`WDOG_US` cycles of entering phase 4, the block enters phase 7 on edge `WDOG_CYC` for one cycle with the peer reset low. It then enters phase 2 and goes through the full `HOLD_CYC` hold again. If completion and expiry fall in the same cycle, completion wins.
- R9: If `train_done_i` is low during phase 4 or phase 5, the next edge moves the block to phase 7, so that `link_up_o` falls at once. A full reset cycle follows.
- R10: `err_o` rises when phase 7 is entered and stays high through later successful bring-ups. Only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| clk_stable_i | input | 1 | Reference clock is stable |
| train_done_i | input | 1 | Peer reports link training complete |
| rx_crd_vld_i | input | 1 | One initial receive credit from the peer per high cycle |
| peer_rst_n_o | output | 1 | Active-low reset to the peer die |
| tx_crd_vld_o | output | 1 | One initial transmit credit to the peer per high cycle |
| link_up_o | output | 1 | Link is operational; commands may be issued |
| phase_o | output | 3 | Current bring-up phase code |
| err_o | output | 1 | Sticky bring-up failure flag |

## Verification
Every output is decoded from registered state, so a change in any input shows up one edge later. The bench drives inputs on the falling edge and samples on the falling edge after the next rising edge. During the exchange the bench numbers cycles from the first cycle in which phase 4 is seen. A strobe driven in cycle k is counted at edge k+1. Link-up is therefore expected in cycle max(32, start+32)+1, and a watchdog expiry exactly in cycle `WDOG_CYC`. Each check samples at precisely that cycle. The reset hold is measured as a count of consecutive phase-2 samples, and that count must equal `HOLD_CYC`.

// File: rtl/lu_pkg.sv
package lu_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WCLK   = 3'd1,
    PH_HOLD   = 3'd2,
    PH_TRAIN  = 3'd3,
    PH_CRED   = 3'd4,
    PH_ACTIVE = 3'd5,
    PH_FAIL   = 3'd7
  } phase_e;

  // microseconds at a given clock rate, as whole clock cycles
  function automatic int us_to_cyc(input int mhz, input int us);
    return mhz * us;
  endfunction

  // width of a counter that must reach the value n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/lu_timer.sv
module lu_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int W = lu_pkg::cnt_w(LIMIT);

  logic [W-1:0] cnt;

  assign hit = run && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!hit)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lu_credit_tx.sv
module lu_credit_tx #(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic vld,
  output logic done
);
  localparam int W = lu_pkg::cnt_w(N);

  logic [W-1:0] sent;

  assign done = (sent == W'(N));
  assign vld  = en && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sent <= '0;
    else if (!en)   sent <= '0;
    else if (vld)   sent <= sent + 1'b1;
  end
endmodule

// File: rtl/lu_credit_rx.sv
module lu_credit_rx #(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic strobe,
  output logic done
);
  localparam int W = lu_pkg::cnt_w(N);

  logic [W-1:0] got;

  assign done = (got == W'(N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 got <= '0;
    else if (!en)               got <= '0;
    else if (strobe && !done)   got <= got + 1'b1;
  end
endmodule

// File: rtl/d2d_linkup_ctrl.sv
module d2d_linkup_ctrl #(
  parameter int CLK_MHZ  = 100,
  parameter int WDOG_US  = 100,
  parameter int CREDITS  = 32,
  parameter int HOLD_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_stable_i,
  input  logic       train_done_i,
  input  logic       rx_crd_vld_i,
  output logic       peer_rst_n_o,
  output logic       tx_crd_vld_o,
  output logic       link_up_o,
  output logic [2:0] phase_o,
  output logic       err_o
);
  import lu_pkg::*;

  localparam int WDOG_CYC = us_to_cyc(CLK_MHZ, WDOG_US);

  phase_e state, state_nxt;
  logic   err_q;

  // named internal events
  logic hold_hit;
  logic wdog_hit;
  logic cred_tx_done;
  logic cred_rx_done;
  logic xchg_done;
  logic in_cred;

  assign in_cred   = (state == PH_CRED);
  assign xchg_done = cred_tx_done && cred_rx_done;

  lu_timer #(.LIMIT(HOLD_CYC)) hold_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(state == PH_HOLD), .hit(hold_hit)
  );

  lu_timer #(.LIMIT(WDOG_CYC)) wdog_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(in_cred), .hit(wdog_hit)
  );

  lu_credit_tx #(.N(CREDITS)) tx_i (
    .clk(clk), .rst_n(rst_n), .en(in_cred), .vld(tx_crd_vld_o), .done(cred_tx_done)
  );

  lu_credit_rx #(.N(CREDITS)) rx_i (
    .clk(clk), .rst_n(rst_n), .en(in_cred), .strobe(rx_crd_vld_i), .done(cred_rx_done)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      PH_IDLE:   state_nxt = PH_WCLK;
      PH_WCLK:   if (clk_stable_i) state_nxt = PH_HOLD;
      PH_HOLD: begin
        if (!clk_stable_i)  state_nxt = PH_WCLK;
        else if (hold_hit)  state_nxt = PH_TRAIN;
      end
      PH_TRAIN:  if (train_done_i) state_nxt = PH_CRED;
      PH_CRED: begin
        if (!train_done_i)  state_nxt = PH_FAIL;
        else if (xchg_done) state_nxt = PH_ACTIVE;
        else if (wdog_hit)  state_nxt = PH_FAIL;
      end
      PH_ACTIVE: if (!train_done_i) state_nxt = PH_FAIL;
      PH_FAIL:   state_nxt = PH_HOLD;
      default:   state_nxt = PH_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      err_q <= 1'b0;
    end else begin
      state <= state_nxt;
      err_q <= err_q | (state_nxt == PH_FAIL);
    end
  end

  assign peer_rst_n_o = (state == PH_TRAIN) || (state == PH_CRED) || (state == PH_ACTIVE);
  assign link_up_o    = (state == PH_ACTIVE);
  assign phase_o      = state;
  assign err_o        = err_q;

endmodule

// File: rtl/lu_ctrl_chk.sv
module lu_ctrl_chk #(
  parameter int CREDITS  = 32,
  parameter int HOLD_CYC = 16,
  parameter int WDOG_CYC = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_stable_i,
  input logic       train_done_i,
  input logic       peer_rst_n_o,
  input logic       tx_crd_vld_o,
  input logic       link_up_o,
  input logic [2:0] phase_o,
  input logic       err_o,
  input logic       cred_tx_done,
  input logic       cred_rx_done
);
  int tx_seen;
  int cred_cyc;
  int hold_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_seen   <= 0;
      cred_cyc  <= 0;
      hold_seen <= 0;
    end else begin
      tx_seen   <= (phase_o == 3'd4) ? tx_seen + (tx_crd_vld_o ? 1 : 0) : 0;
      cred_cyc  <= (phase_o == 3'd4) ? cred_cyc + 1 : 0;
      hold_seen <= (phase_o == 3'd2) ? hold_seen + 1 : 0;
    end
  end

  // R2
  peer_rel_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(peer_rst_n_o) |-> $past(clk_stable_i));

  // R3
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd3 && $past(phase_o) == 3'd2) |-> $past(hold_seen) == HOLD_CYC - 1);

  // R4
  tx_after_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_crd_vld_o) |-> $past(train_done_i));

  // R5
  tx_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_seen <= CREDITS);

  // R7
  up_after_xchg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up_o) |-> $past(cred_tx_done && cred_rx_done));

  // R8
  wdog_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd4) |-> cred_cyc < WDOG_CYC);

  // R9
  drop_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up_o && !train_done_i) |=> (!link_up_o && phase_o == 3'd7));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

endmodule

bind d2d_linkup_ctrl lu_ctrl_chk #(
  .CREDITS(CREDITS), .HOLD_CYC(HOLD_CYC), .WDOG_CYC(WDOG_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_stable_i(clk_stable_i), .train_done_i(train_done_i),
  .peer_rst_n_o(peer_rst_n_o), .tx_crd_vld_o(tx_crd_vld_o), .link_up_o(link_up_o),
  .phase_o(phase_o), .err_o(err_o), .cred_tx_done(cred_tx_done), .cred_rx_done(cred_rx_done)
);

// File: tb/d2d_linkup_ctrl_tb_top.sv
module d2d_linkup_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ   = 1;
  localparam int US    = 100;
  localparam int NCRED = 32;
  localparam int HOLD  = 8;
  localparam int WDOG  = MHZ * US;

  // {rx start cycle, rx credit count}
  localparam int NVEC = 6;
  localparam int VEC [NVEC][2] = '{
    '{0, 32}, '{10, 32}, '{67, 32}, '{68, 32}, '{0, 31}, '{5, 45}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_stable_i = 1'b0;
  logic train_done_i = 1'b0;
  logic rx_crd_vld_i = 1'b0;
  logic peer_rst_n_o, tx_crd_vld_o, link_up_o, err_o;
  logic [2:0] phase_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  d2d_linkup_ctrl #(.CLK_MHZ(MHZ), .WDOG_US(US), .CREDITS(NCRED), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_stable_i(clk_stable_i), .train_done_i(train_done_i),
    .rx_crd_vld_i(rx_crd_vld_i), .peer_rst_n_o(peer_rst_n_o), .tx_crd_vld_o(tx_crd_vld_o),
    .link_up_o(link_up_o), .phase_o(phase_o), .err_o(err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx_crd_vld_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_phase(input int ph, output int ok);
    ok = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (phase_o == 3'(ph)) begin ok = 1; break; end
    end
  endtask

  // called at the falling edge where phase 4 is first seen (cycle 0)
  task automatic run_xchg(input int st, input int num,
                          output int up_at, output int err_at,
                          output int tx_n, output int tx_last);
    up_at = -1; err_at = -1; tx_n = 0; tx_last = -1;
    for (int k = 0; k < WDOG + 6; k++) begin
      if (link_up_o && up_at < 0) up_at = k;
      if (phase_o == 3'd7 && err_at < 0) err_at = k;
      if (tx_crd_vld_o) begin tx_n++; tx_last = k; end
      if (up_at >= 0 || err_at >= 0) break;
      rx_crd_vld_i = (k >= st && k < st + num);
      @(negedge clk);
    end
    rx_crd_vld_i = 1'b0;
  endtask

  // from a falling edge just before phase 2, count consecutive phase-2 samples
  task automatic count_hold(output int n);
    n = 0;
    @(negedge clk);
    while (phase_o == 3'd2 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run ended)");
      summary();
    end
  end

  initial begin
    int ok, up_at, err_at, tx_n, tx_last, c, n, exp_up;

    // vector table: full bring-up, then credit exchange variants
    for (int v = 0; v < NVEC; v++) begin
      clk_stable_i = 1'b1;
      train_done_i = 1'b1;
      do_reset();
      wait_phase(4, ok);
      check("R4 reach exchange", ok, 1);
      run_xchg(VEC[v][0], VEC[v][1], up_at, err_at, tx_n, tx_last);
      c = (VEC[v][0] > 0) ? VEC[v][0] + NCRED : NCRED;
      exp_up = (VEC[v][1] >= NCRED && c <= WDOG - 1) ? 1 : 0;
      // R5 credit count and contiguity
      check("R5 tx credits", tx_n, NCRED);
      check("R5 last tx cycle", tx_last, NCRED - 1);
      if (exp_up == 1) begin
        check("R7 link-up cycle", up_at, c + 1);
        check("R6 R7 no error", err_at, -1);
        check("R7 phase active", int'(phase_o), 5);
        check("R10 err clear", int'(err_o), 0);
      end else begin
        check("R8 expiry cycle", err_at, WDOG);
        check("R6 no link-up", up_at, -1);
        check("R8 err set", int'(err_o), 1);
      end
    end

    // R1 reset state
    clk_stable_i = 1'b0;
    train_done_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 idle phase", int'(phase_o), 0);
    check("R1 peer reset low", int'(peer_rst_n_o), 0);
    check("R1 link down", int'(link_up_o), 0);
    check("R1 err low", int'(err_o), 0);
    check("R1 no tx", int'(tx_crd_vld_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 to wait-clock", int'(phase_o), 1);

    // R2 hold in phase 1 without stable clock
    repeat (5) @(negedge clk);
    check("R2 still waiting", int'(phase_o), 1);
    check("R2 peer reset low", int'(peer_rst_n_o), 0);

    // R3 clock loss during hold returns to phase 1
    clk_stable_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 in hold", int'(phase_o), 2);
    clk_stable_i = 1'b0;
    @(negedge clk);
    check("R3 back to wait-clock", int'(phase_o), 1);

    // R3 full hold length
    clk_stable_i = 1'b1;
    count_hold(n);
    check("R3 hold cycles", n, HOLD);
    check("R3 training phase", int'(phase_o), 3);
    check("R3 peer reset released", int'(peer_rst_n_o), 1);

    // R4 and R6: no credits before training, strobes in phase 3 ignored
    for (int i = 0; i < 6; i++) begin
      rx_crd_vld_i = 1'b1;
      @(negedge clk);
      check("R4 no tx in training", int'(tx_crd_vld_o), 0);
      check("R4 stays training", int'(phase_o), 3);
    end
    rx_crd_vld_i = 1'b0;
    train_done_i = 1'b1;
    @(negedge clk);
    check("R4 exchange entered", int'(phase_o), 4);

    // R6 31 credits plus the ignored 6 must not bring the link up; R8 expiry
    run_xchg(0, NCRED - 1, up_at, err_at, tx_n, tx_last);
    check("R6 ignored strobes", up_at, -1);
    check("R8 expiry cycle", err_at, WDOG);
    check("R8 peer reset in error", int'(peer_rst_n_o), 0);
    check("R8 err set", int'(err_o), 1);
    count_hold(n);
    check("R8 full hold after error", n, HOLD);
    @(negedge clk);
    check("R8 retry exchange", int'(phase_o), 4);

    // R10 sticky error across successful retry
    run_xchg(0, NCRED, up_at, err_at, tx_n, tx_last);
    check("R10 retry link-up", up_at, NCRED + 1);
    check("R10 err still set", int'(err_o), 1);

    // R9 training loss while active
    train_done_i = 1'b0;
    @(negedge clk);
    check("R9 link dropped", int'(link_up_o), 0);
    check("R9 error phase", int'(phase_o), 7);
    @(negedge clk);
    check("R9 full reset cycle", int'(phase_o), 2);

    // R10 cleared only by block reset
    do_reset();
    @(negedge clk);
    check("R10 err cleared by reset", int'(err_o), 0);

    finished = 1'b1;
    summary();
  end
endmodule